// File: doc/BRIEF.md
# External Interrupt Detection Controller

This block watches up to eight external interrupt pins of an 8-bit microcontroller and turns the condition chosen for each pin into a pending flag and a request to the core. Every pin is brought into the clock domain through two flip-flops. Each pin has its own configuration: it is sensed either by level or by edge, and a polarity bit selects which level or which edge counts.

Four byte-wide registers hold the configuration and the flags: pending flags, sense mode, polarity and request enable. Each of them can be read and written over a simple register bus. A flag is cleared in one of two ways: the core pulses the pin's acknowledge as it enters the service routine, or software writes a 0 to that flag bit. A request reaches the core only while the pin's enable bit is set.

Top module: `extint_ctrl`

## Requirements
- R1: While reset is asserted and right after it, all four registers read 00h and every request output is 0.
- R2: The flag, mode, polarity and enable registers sit at BASE_ADDR+0, +1, +2 and +3 (ACh to AFh by default). Bit i of each register belongs to pin i. A write with bus_wr high updates the addressed register at the next clock edge. bus_rdata shows the addressed register combinationally, and any other address reads 00h. The mode, polarity and enable registers change only when they are written.
- R3: A mode bit of 0 selects level sensing for its pin, and a mode bit of 1 selects edge sensing.
- R4: In level mode, a polarity bit of 0 makes a low pin active and a polarity bit of 1 makes a high pin active. The flag is set on every clock for as long as the active level persists, even right after the flag has been cleared.
- R5: In edge mode, a polarity bit of 0 detects a falling edge and a polarity bit of 1 detects a rising edge. An edge is found by comparing the synchronised pin value with its value one clock earlier.
- R6: Each pin passes through a two-flop synchroniser. A qualifying pin change made before clock edge k shows in the flag after edge k+2, and not before.
- R7: A 1 on ack_i[i] clears flag i at the next clock edge.
- R8: A write to the flag register clears every flag whose data bit is 0. Writing 1 to a flag bit leaves it unchanged.
- R9: If a set condition and a clear (acknowledge or write of 0) fall on the same clock, the flag ends up set.
- R10: irq_o[i] is 1 exactly when flag i and enable i are both 1. A pin with enable 0 never raises a request.
- R11: Writing a pin's mode or polarity does not by itself set its flag in edge mode, because edge detection uses only the pin history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | External interrupt pins, asynchronous |
| ack_i | input | N_PINS | Per-pin service acknowledge from the core |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_o | output | N_PINS | Per-pin interrupt request |

## Verification
The bench goes after these corner cases:

- **Clear and set on the same clock.** Flags are cleared while a level condition is still active, and acknowledges arrive as edges land. A design that let the clear win would drop events, or would leave a level-mode flag low while the pin is still active.
- **Latency.** The bench measures the exact number of clocks from a pin edge to its flag. A synchroniser that is too short or too long would show the flag one clock early or one clock late.
- **Configuration writes while pins sit still.** Mode and polarity are rewritten while the pins do not move. A design that compared configured values rather than pin history would set spurious edge flags.
- **Write-1 and disabled pins.** Writes of 1 to the flag register must leave the flags alone, and disabled pins must raise no request. Mistakes here show as flags appearing from a write, or as requests leaking from disabled pins.

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int N_PINS = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] ack_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PINS-1:0] irq_o
);

  localparam logic [ADDR_W-1:0] A_FLAG = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_MODE = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_POL  = BASE_ADDR + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EN   = BASE_ADDR + ADDR_W'(3);

  logic [N_PINS-1:0] sync1, sync2, sync3;
  logic [N_PINS-1:0] flag_q, mode_q, pol_q, en_q;
  logic [N_PINS-1:0] hit, clr;

  wire wr_flag = bus_wr && (bus_addr == A_FLAG);
  wire wr_mode = bus_wr && (bus_addr == A_MODE);
  wire wr_pol  = bus_wr && (bus_addr == A_POL);
  wire wr_en   = bus_wr && (bus_addr == A_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic rise_w, fall_w, lvl_w;
    assign rise_w = sync2[i] & ~sync3[i];
    assign fall_w = ~sync2[i] & sync3[i];
    assign lvl_w  = ~(sync2[i] ^ pol_q[i]);
    assign hit[i] = mode_q[i] ? (pol_q[i] ? rise_w : fall_w) : lvl_w;
  end

  assign clr = ack_i | ({N_PINS{wr_flag}} & ~bus_wdata[N_PINS-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | hit;
      if (wr_mode) mode_q <= bus_wdata[N_PINS-1:0];
      if (wr_pol)  pol_q  <= bus_wdata[N_PINS-1:0];
      if (wr_en)   en_q   <= bus_wdata[N_PINS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAG:  bus_rdata[N_PINS-1:0] = flag_q;
      A_MODE:  bus_rdata[N_PINS-1:0] = mode_q;
      A_POL:   bus_rdata[N_PINS-1:0] = pol_q;
      A_EN:    bus_rdata[N_PINS-1:0] = en_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = flag_q & en_q;

endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter int N_PINS = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hAC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_PINS-1:0] ack_i,
  input logic [N_PINS-1:0] irq_o,
  input logic [N_PINS-1:0] flag_q,
  input logic [N_PINS-1:0] mode_q,
  input logic [N_PINS-1:0] pol_q,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] hit
);

  localparam logic [ADDR_W-1:0] A_LO = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HI = BASE_ADDR + ADDR_W'(3);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~en_q) == '0); // R10

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr >= A_LO && bus_addr <= A_HI)
      |=> ($stable(mode_q) && $stable(pol_q) && $stable(en_q))); // R2

  for (genvar k = 0; k < N_PINS; k++) begin : g_bit
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> flag_q[k]); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[k] && !hit[k]) |=> !flag_q[k]); // R7
    AST_WR0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BASE_ADDR && !bus_wdata[k] && !hit[k]) |=> !flag_q[k]); // R8
    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[k]) |-> $past(hit[k])); // R3
  end

endmodule

bind extint_ctrl extint_ctrl_chk #(
  .N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) chk_i (.*);

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;

  localparam logic [7:0] BASE = 8'hAC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'hFF;
  logic [7:0] ack = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] addr = BASE;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  bit [7:0] m_s1, m_s2, m_s3, m_flag, m_mode, m_pol, m_en;

  always #5 clk = ~clk;

  extint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .ack_i(ack), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic bit [7:0] exp_hit();
    bit [7:0] h;
    for (int i = 0; i < 8; i++) begin
      if (m_mode[i]) h[i] = m_pol[i] ? (m_s2[i] & ~m_s3[i]) : (~m_s2[i] & m_s3[i]);
      else           h[i] = (m_s2[i] == m_pol[i]);
    end
    return h;
  endfunction

  function automatic bit [7:0] exp_read(bit [7:0] a);
    case (a)
      BASE:        return m_flag;
      BASE + 8'd1: return m_mode;
      BASE + 8'd2: return m_pol;
      BASE + 8'd3: return m_en;
      default:     return 8'h00;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    {m_s1, m_s2, m_s3, m_flag, m_mode, m_pol, m_en} = '0;
  endtask

  task automatic model_step();
    bit [7:0] h, c;
    h = exp_hit();
    c = ack | ((wr && addr == BASE) ? ~wdata : 8'h00);
    m_flag = (m_flag & ~c) | h;
    if (wr && addr == BASE + 8'd1) m_mode = wdata;
    if (wr && addr == BASE + 8'd2) m_pol = wdata;
    if (wr && addr == BASE + 8'd3) m_en = wdata;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
    check(irq === (m_flag & m_en), "R10 irq", irq, m_flag & m_en);
    check(rdata === exp_read(addr), "R2 rdata", rdata, exp_read(addr));
  endtask

  task automatic wr_reg(bit [1:0] off, bit [7:0] d);
    addr = BASE + 8'(off); wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_exp(bit [1:0] off, bit [7:0] e, string req);
    addr = BASE + 8'(off);
    #1;
    check(rdata === e, req, rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      addr = BASE + 8'(r);
      #1;
      check(rdata === 8'h00, "R1 reset regs", rdata, 8'h00);
    end
    check(irq === 8'h00, "R1 reset irq", irq, 8'h00);
    rst_n = 1'b1;
    addr = BASE + 8'd3;
    tick();
    rd_exp(2'd3, 8'h00, "R1 enable after reset");
    repeat (3) tick();

    // pins high, low-level default: flags came from reset sync state; clear them
    wr_reg(2'd0, 8'h00);
    rd_exp(2'd0, 8'h00, "R8 write0 clears");
    wr_reg(2'd0, 8'hFF);
    rd_exp(2'd0, 8'h00, "R8 write1 no effect");
    addr = BASE + 8'h10; #1;
    check(rdata === 8'h00, "R2 unmapped reads zero", rdata, 8'h00);

    // high level active on all pins, enable pin 0 only
    wr_reg(2'd3, 8'h01);
    wr_reg(2'd2, 8'hFF);
    tick();
    rd_exp(2'd0, 8'hFF, "R4 high level sets");
    check(irq === 8'h01, "R10 only enabled request", irq, 8'h01);
    wr_reg(2'd0, 8'h00);
    rd_exp(2'd0, 8'hFF, "R9 set wins over write0");
    ack = 8'hFF; tick(); ack = 8'h00;
    rd_exp(2'd0, 8'hFF, "R4 level re-sets after ack");

    // switch to rising edge while pins stay high: no spurious flag
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd0, 8'h00);
    repeat (2) tick();
    rd_exp(2'd0, 8'h00, "R11 no spurious edge on mode write");
    wr_reg(2'd2, 8'h00);
    repeat (2) tick();
    rd_exp(2'd0, 8'h00, "R11 no spurious edge on polarity write");
    wr_reg(2'd2, 8'hFF);

    // rising-edge latency on pin 0
    pin[0] = 1'b0; repeat (4) tick();
    rd_exp(2'd0, 8'h00, "R5 falling ignored in rising mode");
    pin[0] = 1'b1;
    repeat (2) tick();
    rd_exp(2'd0, 8'h00, "R6 not before third edge");
    tick();
    rd_exp(2'd0, 8'h01, "R6 flag on third edge");
    check(irq === 8'h01, "R5 rising edge request", irq, 8'h01);
    repeat (2) tick();
    rd_exp(2'd0, 8'h01, "R5 edge flag held");
    ack = 8'h01; tick(); ack = 8'h00;
    rd_exp(2'd0, 8'h00, "R7 ack clears");

    // falling edge on pin 1 with ack landing on the set clock
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h02);
    pin[1] = 1'b0;
    repeat (2) tick();
    ack = 8'h02; tick(); ack = 8'h00;
    rd_exp(2'd0, 8'h02, "R9 set wins over ack");
    check(irq === 8'h02, "R5 falling edge request", irq, 8'h02);
    wr_reg(2'd0, 8'h00);

    // level low on pin 1 via mode 0
    wr_reg(2'd1, 8'hFD);
    tick();
    rd_exp(2'd0, 8'h02, "R3 mode0 selects level");

    // random traffic checked against the model every clock
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) pin = pin ^ (8'd1 << r[6:4]);
      ack = (r[9:7] == 3'd0) ? 8'($urandom) : 8'h00;
      wr = (r[11:10] == 2'd0);
      addr = BASE + 8'(r[14:12] % 5);
      wdata = 8'($urandom);
      tick();
    end
    wr = 1'b0; ack = 8'h00;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule